// File: doc/BRIEF.md
# FM Sound Chip Interval Timer Pair

This block holds the two interval timers and the two overflow status flags of an FM sound chip register interface. A host writes through two ports. Each port has an index write, which latches a register number, and a data write, which stores into the register that was latched. Only the timer registers are decoded here. Timer A has a 10-bit reload value that is split over two registers. Timer B has an 8-bit reload value. A control register starts and stops each timer, gates its overflow into the status byte, and clears the flags.

Counting advances on a one-cycle `tick` pulse that the surrounding chip supplies as its timer-A time base. Timer B counts one step for every sixteen such ticks. The status byte carries the flags in its two low bits, and `irq` is raised while either flag is set. All pins are plain control and status signals. A write takes effect in the cycle it is presented, so there is no back-pressure.

Top module: `fm_timer_pair`

## Requirements
- R1: `wr_addr` 0 or 2 with `wr_en` latches `wr_data` as the register index and selects bank 0 (addr 0) or bank 1 (addr 2). A data write at `wr_addr` 1 takes effect only when bank 0 is selected. A data write at `wr_addr` 3 takes effect only when bank 1 is selected. Any other data write is ignored. The timer registers exist only in bank 0.
- R2: Index 0x24 writes timer A value bits 9..2 from `wr_data[7:0]`. Index 0x25 writes bits 1..0 from `wr_data[1:0]`, and the upper data bits are ignored.
- R3: After timer A is started with value TA, its overflow happens on the (1024 - TA)th tick. Its flag (status bit 0) is visible in the cycle after that tick is sampled.
- R4: Index 0x26 sets TB. After timer B is started, it overflows on tick number (256 - TB) * 16, and its flag is status bit 1. The divide-by-16 phase restarts when timer B starts.
- R5: In control index 0x27, bit 0 runs timer A and bit 1 runs timer B. A 0-to-1 change of a run bit loads a full period. A stopped timer never overflows.
- R6: A running timer reloads its period on each overflow and keeps counting, without being restarted.
- R7: Control bit 2 lets a timer A overflow set status bit 0. Control bit 3 does the same for timer B and status bit 1. An overflow with its enable clear leaves the flag at 0.
- R8: A write to 0x27 with bit 4 set clears status bit 0, and with bit 5 set clears status bit 1. If an enabled overflow falls in the same cycle as the clear, the flag ends set.
- R9: `status[7:2]` are always 0. `irq` is 1 exactly while either status flag is 1.
- R10: A new timer value written while that timer runs does not change the period in progress. It is used from the next reload on.
- R11: After reset, the status is 0, `irq` is 0, both timers are stopped, bank 0 is selected and the latched index is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the selected address |
| wr_addr | input | 2 | 0/2: index latch port 0/1; 1/3: data port 0/1 |
| wr_data | input | 8 | Write data |
| tick | input | 1 | One-cycle timer-A time base pulse |
| status | output | 8 | Bit 0 timer A flag, bit 1 timer B flag, rest 0 |
| irq | output | 1 | Interrupt request, OR of both flags |

## Verification
The one collision that matters is a flag clear written to the control register in the same cycle that an enabled overflow happens. The bench provokes it by counting a running timer to one tick short of overflow, latching the control index, and then presenting the last tick together with the clearing data write. The flag must stay set afterwards, and a second clear with no tick must then drop it. A reload that falls in the same cycle as a run-bit write that leaves the timer running is exercised as well: the period must not restart.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  localparam int TA_W   = 10;
  localparam int TB_W   = 8;
  localparam int CNT_W  = TA_W + 1;
  localparam int IDX_W  = 8;
  localparam logic [IDX_W-1:0] IDX_TA_HI = 8'h24;
  localparam logic [IDX_W-1:0] IDX_TA_LO = 8'h25;
  localparam logic [IDX_W-1:0] IDX_TB    = 8'h26;
  localparam logic [IDX_W-1:0] IDX_CTL   = 8'h27;
  localparam int NUM_TMR = 2;
endpackage

// File: rtl/fmt_regif.sv
module fmt_regif
  import fmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [7:0]           wr_data,
  output logic [TA_W-1:0]      ta_val,
  output logic [TB_W-1:0]      tb_val,
  output logic [NUM_TMR-1:0]   run_q,
  output logic [NUM_TMR-1:0]   en_q,
  output logic [NUM_TMR-1:0]   start,
  output logic [NUM_TMR-1:0]   clr,
  output logic                 bank_q,
  output logic [IDX_W-1:0]     idx_q
);
  logic data_ok, lo_bank;
  logic hit_ta_hi, hit_ta_lo, hit_tb, hit_ctl;

  // data port must match the bank chosen by the last index write
  assign data_ok   = wr_en && wr_addr[0] && (wr_addr[1] == bank_q);
  assign lo_bank   = data_ok && !bank_q;
  assign hit_ta_hi = lo_bank && (idx_q == IDX_TA_HI);
  assign hit_ta_lo = lo_bank && (idx_q == IDX_TA_LO);
  assign hit_tb    = lo_bank && (idx_q == IDX_TB);
  assign hit_ctl   = lo_bank && (idx_q == IDX_CTL);

  assign start = {NUM_TMR{hit_ctl}} & wr_data[NUM_TMR-1:0] & ~run_q;
  assign clr   = {NUM_TMR{hit_ctl}} & wr_data[5:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
      idx_q  <= '0;
    end else if (wr_en && !wr_addr[0]) begin
      bank_q <= wr_addr[1];
      idx_q  <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ta_val <= '0;
      tb_val <= '0;
      run_q  <= '0;
      en_q   <= '0;
    end else begin
      if (hit_ta_hi) ta_val[TA_W-1:2] <= wr_data;
      if (hit_ta_lo) ta_val[1:0]      <= wr_data[1:0];
      if (hit_tb)    tb_val           <= wr_data;
      if (hit_ctl) begin
        run_q <= wr_data[1:0];
        en_q  <= wr_data[3:2];
      end
    end
  end
endmodule

// File: rtl/fmt_prescale.sv
module fmt_prescale #(
  parameter int DIV_LOG2 = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  output logic step
);
  logic [DIV_LOG2-1:0] phase_q;

  assign step = tick && (&phase_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (tick)    phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/fmt_interval.sv
module fmt_interval #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          run,
  input  logic          step,
  input  logic [CW-1:0] period,
  output logic          ovf
);
  logic [CW-1:0] cnt_q;

  assign ovf = run && step && (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (start)
      cnt_q <= period;
    else if (run && step)
      cnt_q <= (cnt_q <= CW'(1)) ? period : cnt_q - CW'(1);
  end
endmodule

// File: rtl/fm_timer_pair.sv
module fm_timer_pair
  import fmt_pkg::*;
#(
  parameter int DIV_LOG2 = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       tick,
  output logic [7:0] status,
  output logic       irq
);
  logic [TA_W-1:0]    ta_val;
  logic [TB_W-1:0]    tb_val;
  logic [NUM_TMR-1:0] run_q, en_q, start, clr, step, ovf, flag_q;
  logic               bank_q;
  logic [IDX_W-1:0]   idx_q;
  logic [CNT_W-1:0]   period [NUM_TMR];

  fmt_regif u_regif (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ta_val(ta_val), .tb_val(tb_val), .run_q(run_q),
    .en_q(en_q), .start(start), .clr(clr), .bank_q(bank_q), .idx_q(idx_q)
  );

  assign period[0] = CNT_W'(1 << TA_W) - CNT_W'(ta_val);
  assign period[1] = CNT_W'(1 << TB_W) - CNT_W'(tb_val);
  assign step[0]   = tick;

  fmt_prescale #(.DIV_LOG2(DIV_LOG2)) u_bdiv (
    .clk(clk), .rst_n(rst_n), .restart(start[1]), .tick(tick), .step(step[1])
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    fmt_interval #(.CW(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .start(start[g]), .run(run_q[g]),
      .step(step[g]), .period(period[g]), .ovf(ovf[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= (flag_q[g] && !clr[g]) || (ovf[g] && en_q[g]);
    end
  end

  assign status = {6'b0, flag_q};
  assign irq    = |flag_q;
endmodule

// File: rtl/fmt_timer_chk.sv
module fmt_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       tick,
  input logic [7:0] status,
  input logic       bank_q,
  input logic [7:0] idx_q,
  input logic [1:0] run_q,
  input logic [1:0] en_q,
  input logic [1:0] ovf
);
  a_r3_flag_a_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> $past(tick));

  a_r4_flag_b_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(tick));

  a_r5_stopped_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q[0] |-> !ovf[0]);

  a_r1_wrong_port: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[0] && (wr_addr[1] != bank_q)) |=> $stable(run_q) && $stable(en_q));

  a_r7_masked_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[0] && !status[0]) |=> !status[0]);

  a_r8_clear_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1 && !bank_q && idx_q == 8'h27 && wr_data[4] && !ovf[0])
    |=> !status[0]);
endmodule

bind fm_timer_pair fmt_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .tick(tick), .status(status), .bank_q(bank_q), .idx_q(idx_q), .run_q(run_q),
  .en_q(en_q), .ovf(ovf)
);

// File: tb/test_fm_timer_pair.sv
module test_fm_timer_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick = 1'b0;
  logic [7:0] status;
  logic       irq;
  int         n_chk = 0;
  int         n_err = 0;

  always #5 clk = ~clk;

  fm_timer_pair i_fm_timer_pair (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick(tick), .status(status), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic en, input logic [1:0] a, input logic [7:0] d, input logic tk);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d; tick = tk;
    @(posedge clk);
    #1;
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] idx, input logic [7:0] val);
    cyc(1'b1, 2'd0, idx, 1'b0);
    cyc(1'b1, 2'd1, val, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 8'h00, 1'b1);
  endtask

  task automatic t_reset;
    chk("R11 status after reset", status, 8'h00);
    chk("R11 irq after reset", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_timer_a;
    wreg(8'h24, 8'hFF);
    wreg(8'h25, 8'h00);
    wreg(8'h27, 8'h35);
    ticks(3);
    chk("R3 before overflow", status, 8'h00);
    ticks(1);
    chk("R3 overflow at 1024-TA", status, 8'h01);
    chk("R9 irq follows flag", {7'b0, irq}, 8'h01);
  endtask

  task automatic t_reload_clear;
    wreg(8'h27, 8'h15);
    chk("R8 clear A", status, 8'h00);
    ticks(3);
    chk("R6 no early reload overflow", status, 8'h00);
    ticks(1);
    chk("R6 overflow after reload", status, 8'h01);
  endtask

  task automatic t_enable_mask;
    wreg(8'h27, 8'h11);
    ticks(4);
    chk("R7 masked overflow", status, 8'h00);
    wreg(8'h27, 8'h05);
    ticks(4);
    chk("R7 enabled overflow", status, 8'h01);
  endtask

  task automatic t_stop;
    wreg(8'h27, 8'h34);
    ticks(10);
    chk("R5 stopped timer silent", status, 8'h00);
    wreg(8'h27, 8'h35);
    ticks(3);
    chk("R5 fresh period on start", status, 8'h00);
    ticks(1);
    chk("R5 overflow after start", status, 8'h01);
  endtask

  task automatic t_bank;
    wreg(8'h27, 8'h30);
    cyc(1'b1, 2'd2, 8'h24, 1'b0);
    cyc(1'b1, 2'd1, 8'h00, 1'b0);
    cyc(1'b1, 2'd0, 8'h25, 1'b0);
    cyc(1'b1, 2'd3, 8'h03, 1'b0);
    wreg(8'h27, 8'h35);
    ticks(3);
    chk("R1 mismatched ports ignored", status, 8'h00);
    ticks(1);
    chk("R1 value kept", status, 8'h01);
    cyc(1'b1, 2'd2, 8'h27, 1'b0);
    cyc(1'b1, 2'd3, 8'h30, 1'b0);
    chk("R1 bank 1 has no control", status, 8'h01);
    wreg(8'h27, 8'h30);
    chk("R1 bank 0 control clears", status, 8'h00);
  endtask

  task automatic t_late_value;
    wreg(8'h27, 8'h35);
    ticks(1);
    wreg(8'h25, 8'hFE);
    ticks(2);
    chk("R10 period in progress kept", status, 8'h00);
    ticks(1);
    chk("R10 first overflow", status, 8'h01);
    wreg(8'h27, 8'h15);
    ticks(1);
    chk("R2 new low bits period", status, 8'h00);
    ticks(1);
    chk("R2 R10 new period used", status, 8'h01);
  endtask

  task automatic t_timer_b;
    wreg(8'h27, 8'h30);
    wreg(8'h26, 8'hFE);
    wreg(8'h27, 8'h0A);
    ticks(31);
    chk("R4 before B overflow", status, 8'h00);
    ticks(1);
    chk("R4 B overflow", status, 8'h02);
    chk("R9 irq from B", {7'b0, irq}, 8'h01);
    wreg(8'h27, 8'h20);
    chk("R8 clear B", status, 8'h00);
  endtask

  task automatic t_collide;
    wreg(8'h25, 8'h00);
    wreg(8'h27, 8'h35);
    ticks(3);
    chk("R8 before collision", status, 8'h00);
    cyc(1'b1, 2'd0, 8'h27, 1'b0);
    cyc(1'b1, 2'd1, 8'h15, 1'b1);
    chk("R8 overflow beats clear", status, 8'h01);
    cyc(1'b1, 2'd1, 8'h15, 1'b0);
    chk("R8 later clear", status, 8'h00);
  endtask

  initial begin : watchdog
    #2000000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    t_reset();
    t_timer_a();
    t_reload_clear();
    t_enable_mask();
    t_stop();
    t_bank();
    t_late_value();
    t_timer_b();
    t_collide();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule